// File: doc/BRIEF.md
# Receiver Lane Bring-Up Controller

This block sits behind the character decoder of one serial receive lane and walks the lane through its bring-up. Each clock it takes one decoded octet together with a control-character flag and two code-error flags. From reset it holds the active-low sync request low, which asks the far-end transmitter for comma characters. Once enough consecutive commas have arrived it releases the request. It then checks the four-multiframe alignment sequence that follows and compares the configuration octets carried in the second multiframe against values programmed locally. If every check passes, it declares the lane ready.

In the data phase the controller monitors the position of control characters against the frame and multiframe boundaries. Error classes are logged in a sticky vector: disparity errors, not-in-table codes, misplaced control characters, and alignment or configuration failures. A per-class resync-enable mask decides which logged classes pull the sync request low again to restart the link. An alignment failure whose class is not enabled leaves the lane parked in an error state. In that state the sync request stays high and the lane is never declared ready.

The frame length in octets and the frame count per multiframe are parameters, and the multiframe length is their product. The minimum comma count is also a parameter.

Top module: `lnkrx_ctrl`

## Requirements
- R1: During and after reset, before any octet is accepted, sync_n_o is 0, lane_ready_o is 0, err_log_o is 0 and cfg_mismatch_o is 0.
- R2: A comma is an octet 0xBC with ctl_i=1. sync_n_o goes to 1 in the cycle after the clock edge that samples the fourth consecutive comma. Any other octet received while sync_n_o is 0 restarts the count from zero.
- R3: After sync release, commas may keep arriving. The first non-comma octet must be the start character 0xBC-free code 0x1C with ctl_i=1, and it marks position 0 of the first alignment multiframe. Any other octet is an alignment failure.
- R4: Each of the four alignment multiframes is OCT_PER_FRAME*FRAMES_PER_MF octets long. It starts with 0x1C (ctl=1), ends with the multiframe-end character 0x7C (ctl=1), and carries only ctl=0 octets in between. A violation sets err_log_o[3] and parks the lane, with sync_n_o=1 and lane_ready_o=0.
- R5: In the second alignment multiframe, positions 1, 2, 3 and 4 carry lane count, converter count, resolution and subclass, in that order. Each is compared with loc_lanes_i, loc_convs_i, loc_res_i and loc_subcls_i. A mismatch at position 1+i sets cfg_mismatch_o[i] and err_log_o[3], and the lane is never declared ready.
- R6: lane_ready_o goes to 1 in the cycle after the edge that samples the 0x7C closing the fourth alignment multiframe, and not earlier.
- R7: In the data phase a control octet is accepted only in two places: 0xFC at the last octet of a frame that is not the last of its multiframe, and 0x7C at the last octet of a multiframe. Any other control octet sets err_log_o[2].
- R8: While sync_n_o is 1, disp_err_i sets err_log_o[0] and nit_err_i sets err_log_o[1]. While sync_n_o is 0 they are not logged.
- R9: When an error of class c (bit c of err_log_o) is raised and resync_en_i[c] is 1, sync_n_o is 0 in the next cycle and lane_ready_o falls. With the bit clear, a data-phase error leaves lane_ready_o at 1.
- R10: Bits of err_log_o and cfg_mismatch_o stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oct_i | input | 8 | Decoded octet |
| ctl_i | input | 1 | Octet is a control character |
| disp_err_i | input | 1 | Running disparity error on this octet |
| nit_err_i | input | 1 | Code not in the decode table |
| loc_lanes_i | input | 8 | Expected lane-count field |
| loc_convs_i | input | 8 | Expected converter-count field |
| loc_res_i | input | 8 | Expected resolution field |
| loc_subcls_i | input | 8 | Expected subclass field |
| resync_en_i | input | 4 | Per-class resync enable (bit order as err_log_o) |
| sync_n_o | output | 1 | Active-low sync request to the transmitter |
| lane_ready_o | output | 1 | Lane is in the data phase |
| err_log_o | output | 4 | Sticky error classes: 0 disparity, 1 not-in-table, 2 misplaced control, 3 alignment/config |
| cfg_mismatch_o | output | 4 | Sticky per-field configuration mismatch |

## Verification
The hardest situations to reach are the per-field configuration mismatches and the multiframe-boundary faults deep inside the alignment sequence. Each needs a full comma run, a correctly placed start character and an exact octet count before the faulty octet lands. The bench builds every bring-up with one parameterised task. That task walks the whole alignment sequence and corrupts exactly one chosen field or one chosen multiframe end, and a fresh reset precedes each case. The sweep therefore covers every configuration field and every multiframe end, with expected bits derived from the index that was corrupted.

// File: rtl/lnkrx_pkg.sv
package lnkrx_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_CGS, ST_CGS_DONE, ST_ILAS0, ST_ILAS1,
    ST_ILAS2, ST_ILAS3, ST_DATA, ST_ERROR
  } lnk_state_e;

  localparam logic [7:0] K_COMMA = 8'hBC;
  localparam logic [7:0] K_START = 8'h1C;
  localparam logic [7:0] K_MFEND = 8'h7C;
  localparam logic [7:0] K_FREND = 8'hFC;

  localparam int ERR_DISP = 0;
  localparam int ERR_NIT  = 1;
  localparam int ERR_CTL  = 2;
  localparam int ERR_ILAS = 3;
  localparam int N_ERR    = 4;
  localparam int N_CFG    = 4;
endpackage

// File: rtl/lnkrx_rst_sync.sv
module lnkrx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];
endmodule

// File: rtl/lnkrx_cgs_cnt.sv
module lnkrx_cgs_cnt #(
  parameter int CGS_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic is_comma,
  output logic done_o
);
  localparam int CW = $clog2(CGS_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(CGS_MIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = en && is_comma && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || !is_comma || done_o) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lnkrx_pos_cnt.sv
module lnkrx_pos_cnt #(
  parameter int OCT_PER_FRAME = 2,
  parameter int FRAMES_PER_MF = 4,
  localparam int MF_LEN = OCT_PER_FRAME * FRAMES_PER_MF,
  localparam int POS_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
  localparam int FPOS_W = (OCT_PER_FRAME > 1) ? $clog2(OCT_PER_FRAME) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  output logic [POS_W-1:0] pos_o,
  output logic             mf_last_o,
  output logic             fr_last_o
);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(MF_LEN - 1);
  localparam logic [FPOS_W-1:0] FPOS_LAST = FPOS_W'(OCT_PER_FRAME - 1);
  localparam logic [POS_W-1:0]  POS_AFTER = (MF_LEN > 1) ? POS_W'(1) : '0;
  localparam logic [FPOS_W-1:0] FPOS_AFTER = (OCT_PER_FRAME > 1) ? FPOS_W'(1) : '0;

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [FPOS_W-1:0] fpos_q, fpos_d;

  assign pos_o     = pos_q;
  assign mf_last_o = (pos_q == POS_LAST);
  assign fr_last_o = (fpos_q == FPOS_LAST);

  always_comb begin
    pos_d  = pos_q;
    fpos_d = fpos_q;
    if (restart) begin
      pos_d  = POS_AFTER;
      fpos_d = FPOS_AFTER;
    end else if (run) begin
      pos_d  = mf_last_o ? '0 : pos_q + 1'b1;
      fpos_d = fr_last_o ? '0 : fpos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fpos_q <= '0;
    end else begin
      pos_q  <= pos_d;
      fpos_q <= fpos_d;
    end
  end
endmodule

// File: rtl/lnkrx_cfg_chk.sv
module lnkrx_cfg_chk #(
  parameter int POS_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cap_en,
  input  logic [POS_W-1:0]                  pos,
  input  logic [7:0]                        oct,
  input  logic [lnkrx_pkg::N_CFG-1:0][7:0]  loc,
  output logic [lnkrx_pkg::N_CFG-1:0]       mm_now_o,
  output logic [lnkrx_pkg::N_CFG-1:0]       mm_log_o
);
  import lnkrx_pkg::*;

  logic [N_CFG-1:0] log_q;

  for (genvar i = 0; i < N_CFG; i++) begin : g_field
    assign mm_now_o[i] = cap_en && (pos == POS_W'(i + 1)) && (oct != loc[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) log_q <= '0;
    else        log_q <= log_q | mm_now_o;
  end

  assign mm_log_o = log_q;
endmodule

// File: rtl/lnkrx_err_log.sv
module lnkrx_err_log (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [lnkrx_pkg::N_ERR-1:0]   ev,
  input  logic [lnkrx_pkg::N_ERR-1:0]   resync_en,
  output logic [lnkrx_pkg::N_ERR-1:0]   log_o,
  output logic                          resync_o
);
  import lnkrx_pkg::*;

  logic [N_ERR-1:0] log_q;

  assign resync_o = |(ev & resync_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) log_q <= '0;
    else        log_q <= log_q | ev;
  end

  assign log_o = log_q;
endmodule

// File: rtl/lnkrx_ctrl.sv
module lnkrx_ctrl #(
  parameter int OCT_PER_FRAME = 2,
  parameter int FRAMES_PER_MF = 4,
  parameter int CGS_MIN       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] oct_i,
  input  logic       ctl_i,
  input  logic       disp_err_i,
  input  logic       nit_err_i,
  input  logic [7:0] loc_lanes_i,
  input  logic [7:0] loc_convs_i,
  input  logic [7:0] loc_res_i,
  input  logic [7:0] loc_subcls_i,
  input  logic [3:0] resync_en_i,
  output logic       sync_n_o,
  output logic       lane_ready_o,
  output logic [3:0] err_log_o,
  output logic [3:0] cfg_mismatch_o
);
  import lnkrx_pkg::*;

  localparam int MF_LEN = OCT_PER_FRAME * FRAMES_PER_MF;
  localparam int POS_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;

  lnk_state_e st_q, st_norm, st_d;

  logic             rst_n_s;
  logic             is_comma, is_start, is_mfend, is_frend;
  logic             cgs_done, pos_restart, pos_run;
  logic [POS_W-1:0] pos;
  logic             mf_last, fr_last;
  logic             in_ilas, ilas_oct_ok, ilas_fail, ctl_bad, log_active;
  logic [N_CFG-1:0] cfg_mm_now;
  logic [N_ERR-1:0] ev;
  logic             resync;
  logic [N_CFG-1:0][7:0] loc_cfg;

  lnkrx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign is_comma = ctl_i && (oct_i == K_COMMA);
  assign is_start = ctl_i && (oct_i == K_START);
  assign is_mfend = ctl_i && (oct_i == K_MFEND);
  assign is_frend = ctl_i && (oct_i == K_FREND);

  lnkrx_cgs_cnt #(.CGS_MIN(CGS_MIN)) u_cgs (
    .clk(clk), .rst_n(rst_n_s), .en(st_q == ST_WAIT_CGS),
    .is_comma(is_comma), .done_o(cgs_done)
  );

  assign pos_run = in_ilas || (st_q == ST_DATA);

  lnkrx_pos_cnt #(.OCT_PER_FRAME(OCT_PER_FRAME), .FRAMES_PER_MF(FRAMES_PER_MF)) u_pos (
    .clk(clk), .rst_n(rst_n_s), .restart(pos_restart), .run(pos_run),
    .pos_o(pos), .mf_last_o(mf_last), .fr_last_o(fr_last)
  );

  assign loc_cfg = {loc_subcls_i, loc_res_i, loc_convs_i, loc_lanes_i};

  lnkrx_cfg_chk #(.POS_W(POS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .cap_en(st_q == ST_ILAS1), .pos(pos),
    .oct(oct_i), .loc(loc_cfg), .mm_now_o(cfg_mm_now), .mm_log_o(cfg_mismatch_o)
  );

  assign in_ilas = (st_q == ST_ILAS0) || (st_q == ST_ILAS1) ||
                   (st_q == ST_ILAS2) || (st_q == ST_ILAS3);

  always_comb begin
    if (pos == '0)   ilas_oct_ok = is_start;
    else if (mf_last) ilas_oct_ok = is_mfend;
    else             ilas_oct_ok = !ctl_i;
  end

  // Sequencing without error overrides.
  always_comb begin
    st_norm     = st_q;
    ilas_fail   = 1'b0;
    ctl_bad     = 1'b0;
    pos_restart = 1'b0;
    unique case (st_q)
      ST_WAIT_CGS: if (cgs_done) st_norm = ST_CGS_DONE;
      ST_CGS_DONE: begin
        if (!is_comma) begin
          if (is_start) begin
            st_norm     = ST_ILAS0;
            pos_restart = 1'b1;
          end else begin
            ilas_fail = 1'b1;
          end
        end
      end
      ST_ILAS0, ST_ILAS1, ST_ILAS2, ST_ILAS3: begin
        if (!ilas_oct_ok || (|cfg_mm_now)) begin
          ilas_fail = 1'b1;
        end else if (mf_last) begin
          unique case (st_q)
            ST_ILAS0: st_norm = ST_ILAS1;
            ST_ILAS1: st_norm = ST_ILAS2;
            ST_ILAS2: st_norm = ST_ILAS3;
            default:  st_norm = ST_DATA;
          endcase
        end
      end
      ST_DATA: begin
        ctl_bad = ctl_i && !((fr_last && !mf_last && is_frend) || (mf_last && is_mfend));
      end
      default: ;
    endcase
  end

  assign log_active     = (st_q != ST_WAIT_CGS);
  assign ev[ERR_DISP]   = log_active && disp_err_i;
  assign ev[ERR_NIT]    = log_active && nit_err_i;
  assign ev[ERR_CTL]    = ctl_bad;
  assign ev[ERR_ILAS]   = ilas_fail;

  lnkrx_err_log u_err (
    .clk(clk), .rst_n(rst_n_s), .ev(ev), .resync_en(resync_en_i),
    .log_o(err_log_o), .resync_o(resync)
  );

  // Error overrides on top of normal sequencing.
  always_comb begin
    st_d = st_norm;
    if (resync)         st_d = ST_WAIT_CGS;
    else if (ilas_fail) st_d = ST_ERROR;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= ST_WAIT_CGS;
    else          st_q <= st_d;
  end

  assign sync_n_o     = (st_q != ST_WAIT_CGS);
  assign lane_ready_o = (st_q == ST_DATA);
endmodule

// File: rtl/lnkrx_ctrl_chk.sv
module lnkrx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] oct_i,
  input logic       ctl_i,
  input logic       disp_err_i,
  input logic       nit_err_i,
  input logic [3:0] resync_en_i,
  input logic       sync_n_o,
  input logic       lane_ready_o,
  input logic [3:0] err_log_o,
  input logic [3:0] cfg_mismatch_o
);
  // R2
  hold_sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n_o && !(ctl_i && oct_i == 8'hBC)) |=> !sync_n_o);

  // R2
  release_after_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n_o) |-> $past(ctl_i && oct_i == 8'hBC));

  // R6
  ready_after_mfend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_ready_o) |-> $past(ctl_i && oct_i == 8'h7C));

  // R6
  ready_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_ready_o |-> sync_n_o);

  // R9
  nit_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n_o && nit_err_i && resync_en_i[1]) |=> !sync_n_o);

  // R9
  disp_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n_o && disp_err_i && resync_en_i[0]) |=> !sync_n_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_log_o & $past(err_log_o)) == $past(err_log_o)));

  // R10
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_mismatch_o & $past(cfg_mismatch_o)) == $past(cfg_mismatch_o)));
endmodule

bind lnkrx_ctrl lnkrx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oct_i(oct_i), .ctl_i(ctl_i),
  .disp_err_i(disp_err_i), .nit_err_i(nit_err_i), .resync_en_i(resync_en_i),
  .sync_n_o(sync_n_o), .lane_ready_o(lane_ready_o),
  .err_log_o(err_log_o), .cfg_mismatch_o(cfg_mismatch_o)
);

// File: tb/lnkrx_ctrl_tb.sv
`timescale 1ns/1ps
module lnkrx_ctrl_tb;
  localparam int F  = 2;
  localparam int K  = 4;
  localparam int ML = F * K;

  logic       clk;
  logic       rst_n;
  logic [7:0] oct_i;
  logic       ctl_i, disp_err_i, nit_err_i;
  logic [3:0] resync_en_i;
  logic       sync_n_o, lane_ready_o;
  logic [3:0] err_log_o, cfg_mismatch_o;
  logic [7:0] loc [4];

  int checks = 0;
  int fails  = 0;

  lnkrx_ctrl #(.OCT_PER_FRAME(F), .FRAMES_PER_MF(K), .CGS_MIN(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .oct_i(oct_i), .ctl_i(ctl_i),
    .disp_err_i(disp_err_i), .nit_err_i(nit_err_i),
    .loc_lanes_i(loc[0]), .loc_convs_i(loc[1]), .loc_res_i(loc[2]), .loc_subcls_i(loc[3]),
    .resync_en_i(resync_en_i), .sync_n_o(sync_n_o), .lane_ready_o(lane_ready_o),
    .err_log_o(err_log_o), .cfg_mismatch_o(cfg_mismatch_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] o, input logic c, input logic de = 0, input logic ne = 0);
    oct_i = o; ctl_i = c; disp_err_i = de; nit_err_i = ne;
    @(posedge clk); #1;
    disp_err_i = 1'b0; nit_err_i = 1'b0;
  endtask

  task automatic do_reset(input logic [3:0] en);
    resync_en_i = en;
    oct_i = 8'h00; ctl_i = 1'b0; disp_err_i = 1'b0; nit_err_i = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic commas(input int n);
    for (int i = 0; i < n; i++) put(8'hBC, 1'b1);
  endtask

  // bad_fld: config field to corrupt (-1 none); bad_mf: multiframe whose end is corrupted (-1 none)
  task automatic ilas(input int bad_fld, input int bad_mf);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < ML; p++) begin
        if (m == 3 && p == ML - 1)
          check("R6 ready low before last octet", lane_ready_o, 0);
        if (p == 0)                 put(8'h1C, 1'b1);
        else if (p == ML - 1)       put((m == bad_mf) ? 8'h33 : 8'h7C, m != bad_mf);
        else if (m == 1 && p <= 4)  put(loc[p-1] ^ ((p - 1 == bad_fld) ? 8'h01 : 8'h00), 1'b0);
        else                        put(8'(m * 16 + p), 1'b0);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    loc[0] = 8'd3; loc[1] = 8'd1; loc[2] = 8'd15; loc[3] = 8'd1;
    do_reset(4'h0);
    // R1
    check("R1 sync_n", sync_n_o, 0);
    check("R1 ready", lane_ready_o, 0);
    check("R1 err_log", err_log_o, 0);
    check("R1 cfg_mismatch", cfg_mismatch_o, 0);

    // R2: runs of 1..3 commas interrupted by data never release sync; R8 errors while low not logged
    for (int n = 1; n <= 3; n++) begin
      commas(n);
      put(8'h1C, 1'b1, 1'b1, 1'b1);
      check("R2 short comma run keeps sync low", sync_n_o, 0);
    end
    check("R8 no log while sync low", err_log_o, 0);
    commas(3);
    check("R2 low after third comma", sync_n_o, 0);
    commas(1);
    check("R2 high after fourth comma", sync_n_o, 1);
    commas(2);
    ilas(-1, -1);
    check("R6 ready after final mf end", lane_ready_o, 1);
    check("R5 no mismatch on good config", cfg_mismatch_o, 0);

    // R7: legal control placement over one multiframe
    for (int p = 0; p < ML; p++) begin
      if (p == ML - 1)      put(8'h7C, 1'b1);
      else if (p % F == F-1) put(8'hFC, 1'b1);
      else                   put(8'h5A, 1'b0);
    end
    check("R7 legal controls no error", err_log_o, 0);
    put(8'hFC, 1'b1);  // position 0: not a frame end
    check("R7 misplaced control logged", err_log_o, 4'b0100);
    check("R9 disabled class keeps ready", lane_ready_o, 1);
    put(8'h11, 1'b0, 1'b1, 1'b0);
    check("R8 disparity logged", err_log_o, 4'b0101);
    for (int i = 0; i < 4; i++) put(8'h22, 1'b0);
    check("R10 log sticky", err_log_o, 4'b0101);

    // R9: enabled not-in-table class forces resync
    do_reset(4'b0010);
    commas(4); ilas(-1, -1);
    check("R9 up before fault", lane_ready_o, 1);
    put(8'h44, 1'b0, 1'b0, 1'b1);
    check("R9 sync low after enabled error", sync_n_o, 0);
    check("R9 ready low after enabled error", lane_ready_o, 0);
    check("R8 nit logged", err_log_o, 4'b0010);
    commas(4); ilas(-1, -1);
    check("R9 relink after resync", lane_ready_o, 1);
    check("R10 log survives relink", err_log_o, 4'b0010);

    // R5: sweep each configuration field
    for (int f = 0; f < 4; f++) begin
      do_reset(4'h0);
      commas(4); ilas(f, -1);
      check("R5 mismatch bit", cfg_mismatch_o, 1 << f);
      check("R5 alignment error class", err_log_o, 4'b1000);
      check("R5 never ready", lane_ready_o, 0);
      check("R4 parked keeps sync high", sync_n_o, 1);
    end

    // R4: sweep each multiframe end
    for (int m = 0; m < 4; m++) begin
      do_reset(4'h0);
      commas(4); ilas(-1, m);
      check("R4 broken mf end", err_log_o, 4'b1000);
      check("R4 never ready", lane_ready_o, 0);
    end

    // R3: wrong first non-comma octet
    do_reset(4'h0);
    commas(5);
    put(8'h55, 1'b0);
    check("R3 bad start logged", err_log_o, 4'b1000);
    ilas(-1, -1);
    check("R3 never ready", lane_ready_o, 0);

    // R9 with alignment class enabled
    do_reset(4'b1000);
    commas(4);
    put(8'h55, 1'b0);
    check("R9 alignment resync", sync_n_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule